// File: doc/BRIEF.md
# Record Mode and Transfer-Count Controller

This block steers one record at a time through a byte-wide compression datapath. A small write-only configuration port picks an operating mode, a record length and a skip count, then starts the record. The mode sets which of the two byte ports is the input and which is the output. It also sets whether bytes pass through unchanged or go through the external compression/decompression engine. The engine and the port FIFOs sit outside the block and appear only as valid/ready streams.

A 32-bit down-counter closes the record once the programmed number of input bytes has been accepted. In the engine modes the controller then holds a flush request until the engine hands over its final byte, which the engine marks as last. In the quiet decompress mode, the first bytes the engine produces are consumed and thrown away until the skip count runs out. The rest of that record is then forwarded without further action. A sticky completion flag and an interrupt line report the end of the record. A sticky error flag records configuration writes that were refused.

Top module: `rec_mode_ctrl`

## Requirements
- R1: The mode field takes codes 0 (compress), 1 (compress pass-through), 2 (decompress), 3 (decompress pass-through) and 4 (quiet decompress). Codes 0 and 1 make port A the input and port B the output. Codes 2, 3 and 4 reverse this, and `port_a_is_out` is 1 for them. The input-side port never shows output valid, and the output-side port never shows input ready.
- R2: In codes 1 and 3, input bytes reach the output port unchanged and in the same order, and `eng_in_valid` stays 0.
- R3: In codes 0, 2 and 4, input bytes go to the engine input in order, and engine output bytes go to the output port in order.
- R4: On start, the remaining count loads from the length register, which may be any value from 0 to 2^32-1. Each accepted input byte decrements it, and no input byte is accepted while it is zero. A record therefore takes exactly the programmed number of input bytes.
- R5: In engine modes, once the count is zero, `eng_flush` is held high until an engine output byte flagged `eng_out_last` is accepted. The record ends on that acceptance.
- R6: In code 4, the first N engine output bytes are consumed and never presented, where N is the skip register captured at start. This includes the last byte when N is large enough. Every later byte of the record is forwarded.
- R7: At record end, `done` and `irq` go to 1. They stay at 1 until a command write with bit 1 set, and record completion in the same cycle takes priority over the clear.
- R8: While a record is active, writes to the mode, length or skip register and start commands are ignored, and they set `cfg_err`. A mode write with code 5, 6 or 7 is also ignored and sets `cfg_err`. A command write with bit 2 set clears `cfg_err`.
- R9: Register addresses are 0 for mode (bits 2:0), 1 for length, 2 for skip, and 3 for command (bit 0 start, bit 1 clear done, bit 2 clear error).
- R10: After reset the block is idle in code 0, with `done`, `irq` and `cfg_err` at 0 and both input-side ready signals at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Write data |
| a_in_valid | input | 1 | Port A inbound byte valid |
| a_in_data | input | 8 | Port A inbound byte |
| a_in_ready | output | 1 | Port A inbound accept |
| a_out_valid | output | 1 | Port A outbound byte valid |
| a_out_data | output | 8 | Port A outbound byte |
| a_out_ready | input | 1 | Port A outbound accept |
| b_in_valid | input | 1 | Port B inbound byte valid |
| b_in_data | input | 8 | Port B inbound byte |
| b_in_ready | output | 1 | Port B inbound accept |
| b_out_valid | output | 1 | Port B outbound byte valid |
| b_out_data | output | 8 | Port B outbound byte |
| b_out_ready | input | 1 | Port B outbound accept |
| eng_in_valid | output | 1 | Byte to engine valid |
| eng_in_data | output | 8 | Byte to engine |
| eng_in_ready | input | 1 | Engine accepts byte |
| eng_flush | output | 1 | Engine must drain and mark its final byte |
| eng_out_valid | input | 1 | Engine output valid |
| eng_out_data | input | 8 | Engine output byte |
| eng_out_last | input | 1 | Engine output byte is the record's final one |
| eng_out_ready | output | 1 | Engine output accepted |
| eng_decomp | output | 1 | Engine direction, 1 for decompress |
| port_a_is_out | output | 1 | Port A acts as output |
| busy | output | 1 | Record active |
| done | output | 1 | Sticky record-complete flag |
| irq | output | 1 | Interrupt request |
| cfg_err | output | 1 | Sticky refused-write flag |

## Verification
Two functions can land in the same cycle: the last byte consumed by the quiet-mode skip and the record-ending last byte from the engine. The sweep provokes this coincidence by setting the skip count to one more than the record length, so the trailing last byte is the one that uses up the skip. The sweep also covers skip counts one above and one below that point. The result is judged by two checks: nothing appears on port A, and `done` and `irq` still rise.

// File: rtl/rec_mode_pkg.sv
// Shared types for the record mode controller: operating modes,
// sequencer states, register addresses and mode decode helpers.
package rec_mode_pkg;

    typedef enum logic [2:0] {
        MODE_CMP       = 3'd0,
        MODE_CMP_PASS  = 3'd1,
        MODE_DEC       = 3'd2,
        MODE_DEC_PASS  = 3'd3,
        MODE_DEC_QUIET = 3'd4
    } op_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_t;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_LEN  = 2'd1;
    localparam logic [1:0] ADDR_SKIP = 2'd2;
    localparam logic [1:0] ADDR_CMD  = 2'd3;

    localparam int CMD_START     = 0;
    localparam int CMD_CLR_DONE  = 1;
    localparam int CMD_CLR_ERR   = 2;

    function automatic logic mode_legal(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic mode_is_pass(input op_mode_t m);
        return (m == MODE_CMP_PASS) || (m == MODE_DEC_PASS);
    endfunction

    function automatic logic mode_a_to_b(input op_mode_t m);
        return (m == MODE_CMP) || (m == MODE_CMP_PASS);
    endfunction

endpackage

// File: rtl/rec_mode_regs.sv
// Configuration registers: mode, length, skip and command decode.
// Assumes busy comes from the sequencer; refuses changes while busy
// and flags refused or illegal writes in a sticky error bit.
module rec_mode_regs
    import rec_mode_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wdata,
    input  logic          busy,
    input  logic          rec_end,
    output op_mode_t      mode,
    output logic [CW-1:0] len,
    output logic [CW-1:0] skip,
    output logic          start,
    output logic          done,
    output logic          err
);

    logic wr_mode, wr_len, wr_skip, wr_cmd;

    // Address decode of the write strobe.
    always_comb begin
        wr_mode = we && (addr == ADDR_MODE);
        wr_len  = we && (addr == ADDR_LEN);
        wr_skip = we && (addr == ADDR_SKIP);
        wr_cmd  = we && (addr == ADDR_CMD);
        start   = wr_cmd && wdata[CMD_START] && !busy;
    end

    // Register file update; set conditions are written last so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_CMP;
            len  <= '0;
            skip <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (wr_cmd && wdata[CMD_CLR_ERR])  err  <= 1'b0;
            if (wr_cmd && wdata[CMD_CLR_DONE]) done <= 1'b0;
            if (wr_mode) begin
                if (busy || !mode_legal(wdata[2:0])) err <= 1'b1;
                else mode <= op_mode_t'(wdata[2:0]);
            end
            if (wr_len) begin
                if (busy) err <= 1'b1;
                else len <= wdata;
            end
            if (wr_skip) begin
                if (busy) err <= 1'b1;
                else skip <= wdata;
            end
            if (wr_cmd && wdata[CMD_START] && busy) err <= 1'b1;
            if (rec_end) done <= 1'b1;
        end
    end

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(wr_cmd && wdata[CMD_CLR_DONE])) |=> done);

    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(wr_cmd && wdata[CMD_CLR_ERR])) |=> err);

endmodule

// File: rtl/rec_mode_seq.sv
// Record sequencer: loads the transfer and skip counters at start,
// counts accepted input bytes down, drains the engine in engine modes
// and pulses rec_end at completion. Assumes the router only reports
// handshakes it allowed through in_open / out_open.
module rec_mode_seq
    import rec_mode_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_mode_t      mode,
    input  logic [CW-1:0] len,
    input  logic [CW-1:0] skip,
    input  logic          in_fire,
    input  logic          drop_fire,
    input  logic          last_fire,
    output logic          busy,
    output logic          in_open,
    output logic          out_open,
    output logic          dropping,
    output logic          flush,
    output logic          rec_end
);

    seq_state_t    state;
    logic [CW-1:0] remaining;
    logic [CW-1:0] skip_left;
    logic          pass;

    // Status decode of the current state and counters.
    always_comb begin
        pass     = mode_is_pass(mode);
        busy     = (state != ST_IDLE);
        in_open  = (state == ST_RUN) && (remaining != '0);
        out_open = (state != ST_IDLE);
        dropping = (skip_left != '0);
        flush    = (state == ST_DRAIN);
        rec_end  = ((state == ST_RUN) && (remaining == '0) && pass) ||
                   ((state == ST_DRAIN) && last_fire);
    end

    // State machine with transfer and skip counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            skip_left <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_RUN;
                        remaining <= len;
                        skip_left <= (mode == MODE_DEC_QUIET) ? skip : '0;
                    end
                end
                ST_RUN: begin
                    if (remaining == '0) state <= pass ? ST_IDLE : ST_DRAIN;
                    else if (in_fire)    remaining <= remaining - 1'b1;
                end
                ST_DRAIN: begin
                    if (last_fire) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (state != ST_IDLE && drop_fire) skip_left <= skip_left - 1'b1;
        end
    end

    p_no_take_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0) |-> !in_fire);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && in_fire) |=> (remaining == $past(remaining) - 1'b1));

    p_drain_engine_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> !pass);

    p_skip_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE || skip_left <= $past(skip_left)));

endmodule

// File: rtl/rec_mode_route.sv
// Combinational stream router: selects the input and output port from
// the mode, sends bytes straight across in pass-through or through the
// engine otherwise, and swallows engine output while dropping.
module rec_mode_route
    import rec_mode_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_mode_t      mode,
    input  logic          in_open,
    input  logic          out_open,
    input  logic          dropping,
    input  logic          a_in_valid,
    input  logic [DW-1:0] a_in_data,
    output logic          a_in_ready,
    output logic          a_out_valid,
    output logic [DW-1:0] a_out_data,
    input  logic          a_out_ready,
    input  logic          b_in_valid,
    input  logic [DW-1:0] b_in_data,
    output logic          b_in_ready,
    output logic          b_out_valid,
    output logic [DW-1:0] b_out_data,
    input  logic          b_out_ready,
    output logic          eng_in_valid,
    output logic [DW-1:0] eng_in_data,
    input  logic          eng_in_ready,
    input  logic          eng_out_valid,
    input  logic [DW-1:0] eng_out_data,
    input  logic          eng_out_last,
    output logic          eng_out_ready,
    output logic          in_fire,
    output logic          drop_fire,
    output logic          last_fire
);

    logic          a2b, pass;
    logic          src_valid, src_ready, dst_valid, dst_ready, eo_fire;
    logic [DW-1:0] src_data, dst_data;

    // Port selection, path selection and handshake bookkeeping.
    always_comb begin
        a2b       = mode_a_to_b(mode);
        pass      = mode_is_pass(mode);
        src_valid = a2b ? a_in_valid : b_in_valid;
        src_data  = a2b ? a_in_data  : b_in_data;
        dst_ready = a2b ? b_out_ready : a_out_ready;

        eng_in_valid  = in_open && !pass && src_valid;
        eng_in_data   = src_data;
        src_ready     = in_open && (pass ? dst_ready : eng_in_ready);
        eng_out_ready = out_open && !pass && (dropping || dst_ready);

        dst_valid = pass ? (in_open && src_valid)
                         : (out_open && eng_out_valid && !dropping);
        dst_data  = pass ? src_data : eng_out_data;

        a_in_ready  = a2b && src_ready;
        b_in_ready  = !a2b && src_ready;
        a_out_valid = !a2b && dst_valid;
        b_out_valid = a2b && dst_valid;
        a_out_data  = dst_data;
        b_out_data  = dst_data;

        in_fire   = src_valid && src_ready;
        eo_fire   = eng_out_valid && eng_out_ready;
        drop_fire = eo_fire && dropping;
        last_fire = eo_fire && eng_out_last;
    end

endmodule

// File: rtl/rec_mode_ctrl.sv
// Top of the record mode and transfer-count controller. Ties the
// configuration registers, the record sequencer and the stream router
// together. Assumes the engine marks its final drained byte with
// eng_out_last while eng_flush is high.
module rec_mode_ctrl
    import rec_mode_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          a_in_valid,
    input  logic [DW-1:0] a_in_data,
    output logic          a_in_ready,
    output logic          a_out_valid,
    output logic [DW-1:0] a_out_data,
    input  logic          a_out_ready,
    input  logic          b_in_valid,
    input  logic [DW-1:0] b_in_data,
    output logic          b_in_ready,
    output logic          b_out_valid,
    output logic [DW-1:0] b_out_data,
    input  logic          b_out_ready,
    output logic          eng_in_valid,
    output logic [DW-1:0] eng_in_data,
    input  logic          eng_in_ready,
    output logic          eng_flush,
    input  logic          eng_out_valid,
    input  logic [DW-1:0] eng_out_data,
    input  logic          eng_out_last,
    output logic          eng_out_ready,
    output logic          eng_decomp,
    output logic          port_a_is_out,
    output logic          busy,
    output logic          done,
    output logic          irq,
    output logic          cfg_err
);

    op_mode_t      mode;
    logic [CW-1:0] len, skip;
    logic          start, rec_end;
    logic          in_open, out_open, dropping;
    logic          in_fire, drop_fire, last_fire;

    rec_mode_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .busy(busy), .rec_end(rec_end),
        .mode(mode), .len(len), .skip(skip), .start(start),
        .done(done), .err(cfg_err)
    );

    rec_mode_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .len(len), .skip(skip), .in_fire(in_fire),
        .drop_fire(drop_fire), .last_fire(last_fire), .busy(busy),
        .in_open(in_open), .out_open(out_open), .dropping(dropping),
        .flush(eng_flush), .rec_end(rec_end)
    );

    rec_mode_route #(.DW(DW)) u_route (
        .mode(mode), .in_open(in_open), .out_open(out_open),
        .dropping(dropping),
        .a_in_valid(a_in_valid), .a_in_data(a_in_data), .a_in_ready(a_in_ready),
        .a_out_valid(a_out_valid), .a_out_data(a_out_data), .a_out_ready(a_out_ready),
        .b_in_valid(b_in_valid), .b_in_data(b_in_data), .b_in_ready(b_in_ready),
        .b_out_valid(b_out_valid), .b_out_data(b_out_data), .b_out_ready(b_out_ready),
        .eng_in_valid(eng_in_valid), .eng_in_data(eng_in_data),
        .eng_in_ready(eng_in_ready), .eng_out_valid(eng_out_valid),
        .eng_out_data(eng_out_data), .eng_out_last(eng_out_last),
        .eng_out_ready(eng_out_ready), .in_fire(in_fire),
        .drop_fire(drop_fire), .last_fire(last_fire)
    );

    // Direction outputs and interrupt mirror of the completion flag.
    always_comb begin
        port_a_is_out = !mode_a_to_b(mode);
        eng_decomp    = !mode_a_to_b(mode);
        irq           = done;
    end

    p_a_side_r1: assert property (@(posedge clk) disable iff (!rst_n)
        port_a_is_out |-> (!a_in_ready && !b_out_valid));

    p_b_side_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !port_a_is_out |-> (!b_in_ready && !a_out_valid));

    p_pass_no_engine_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_is_pass(mode) |-> (!eng_in_valid && !eng_out_ready));

    p_flush_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_flush |-> (!a_in_ready && !b_in_ready));

endmodule

// File: tb/rec_mode_ctrl_test.sv
module rec_mode_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        a_in_valid = 1'b0, a_out_ready = 1'b0;
    logic        b_in_valid = 1'b0, b_out_ready = 1'b0;
    logic [7:0]  a_in_data = '0, b_in_data = '0, eng_out_data = '0;
    logic        eng_in_ready = 1'b0, eng_out_valid = 1'b0, eng_out_last = 1'b0;
    logic        a_in_ready, a_out_valid, b_in_ready, b_out_valid;
    logic [7:0]  a_out_data, b_out_data, eng_in_data;
    logic        eng_in_valid, eng_flush, eng_out_ready, eng_decomp;
    logic        port_a_is_out, busy, done, irq, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [15:0] lfsr = 16'hACE1;

    rec_mode_ctrl uut (.*);

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] ad, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // One full record with a bench engine model and randomized stalls.
    task automatic run_record(input int md, input int len, input int skp);
        logic [7:0] src[8];
        logic [7:0] full[9];
        logic [7:0] eq[16];
        logic [7:0] aout[16];
        logic [7:0] bout[16];
        int si = 0, eh = 0, et = 0, ai = 0, bi = 0, nexp, wrong = 0, eng_used = 0;
        bit fl_seen = 0, tr_done = 0, ok, a2b;
        a2b = (md < 2);
        for (int i = 0; i < len; i++) src[i] = 8'(8'h11 * md + 8'h07 * i + skp);
        for (int i = 0; i < len; i++) full[i] = src[i];
        full[len] = 8'hEE;
        cfg_write(2'd0, 32'(md));
        cfg_write(2'd1, 32'(len));
        cfg_write(2'd2, 32'(skp));
        cfg_write(2'd3, 32'h1);
        for (int c = 0; c < 400; c++) begin
            lfsr = step(lfsr);
            if (a2b) begin
                a_in_valid = (si < len) && lfsr[0]; a_in_data = src[si % 8];
                b_in_valid = 1'b1; b_in_data = 8'h55;
                a_out_ready = 1'b1; b_out_ready = lfsr[1] | lfsr[6];
            end else begin
                b_in_valid = (si < len) && lfsr[0]; b_in_data = src[si % 8];
                a_in_valid = 1'b1; a_in_data = 8'h55;
                b_out_ready = 1'b1; a_out_ready = lfsr[1] | lfsr[6];
            end
            eng_in_ready  = lfsr[2] | lfsr[3];
            eng_out_valid = ((eh != et) || (fl_seen && !tr_done)) && (lfsr[4] | lfsr[5]);
            eng_out_data  = (eh != et) ? eq[eh % 16] : 8'hEE;
            eng_out_last  = (eh == et);
            #2;
            if (a_in_valid && a_in_ready) begin if (a2b) si++; else wrong++; end
            if (b_in_valid && b_in_ready) begin if (!a2b) si++; else wrong++; end
            if (eng_in_valid) eng_used++;
            if (eng_in_valid && eng_in_ready) begin eq[et % 16] = eng_in_data; et++; end
            if (eng_out_valid && eng_out_ready) begin
                if (eh != et) eh++; else tr_done = 1;
            end
            if (a_out_valid && a_out_ready) begin if (ai < 16) aout[ai] = a_out_data; ai++; end
            if (b_out_valid && b_out_ready) begin if (bi < 16) bout[bi] = b_out_data; bi++; end
            if (eng_flush) fl_seen = 1;
            @(negedge clk);
            if (done) break;
        end
        a_in_valid = 0; b_in_valid = 0; eng_out_valid = 0;
        // R4: exactly len input bytes taken, none on the wrong side (R1)
        check(si == len && wrong == 0, $sformatf("R4/R1 md%0d len%0d input count", md, len), si, len);
        check(done && irq, $sformatf("R7 md%0d len%0d skp%0d done", md, len, skp), {done, irq}, 3);
        if (md == 1 || md == 3) begin
            ok = (eng_used == 0) && (a2b ? (bi == len && ai == 0) : (ai == len && bi == 0));
            for (int i = 0; i < len; i++) ok &= a2b ? (bout[i] == src[i]) : (aout[i] == src[i]);
            check(ok, $sformatf("R2 pass md%0d len%0d", md, len), a2b ? bi : ai, len);
        end else if (md == 0 || md == 2) begin
            ok = a2b ? (bi == len + 1 && ai == 0) : (ai == len + 1 && bi == 0);
            for (int i = 0; i <= len; i++) ok &= a2b ? (bout[i] == full[i]) : (aout[i] == full[i]);
            check(ok && fl_seen, $sformatf("R3/R5 engine md%0d len%0d", md, len), a2b ? bi : ai, len + 1);
        end else begin
            nexp = (skp >= len + 1) ? 0 : len + 1 - skp;
            ok = (ai == nexp) && (bi == 0);
            for (int i = 0; i < nexp; i++) ok &= (aout[i] == full[skp + i]);
            check(ok, $sformatf("R6 quiet len%0d skp%0d", len, skp), ai, nexp);
        end
        cfg_write(2'd3, 32'h2);
        check(!done && !irq, "R7 clear done", done, 0);
    endtask

    initial begin
        int got;
        @(negedge clk); @(negedge clk);
        // R10: reset state
        check(!busy && !done && !irq && !cfg_err, "R10 reset flags", {busy, done, irq, cfg_err}, 0);
        check(!port_a_is_out && !a_in_ready && !b_in_ready, "R10 reset dir/ready",
              {port_a_is_out, a_in_ready, b_in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: direction per mode code
        for (int m = 0; m < 5; m++) begin
            cfg_write(2'd0, 32'(m));
            check(port_a_is_out == (m >= 2) && eng_decomp == (m >= 2), "R1 direction",
                  port_a_is_out, (m >= 2));
        end
        // R8: illegal mode code refused
        cfg_write(2'd0, 32'd2);
        cfg_write(2'd0, 32'd6);
        check(cfg_err && port_a_is_out, "R8 illegal mode", {cfg_err, port_a_is_out}, 3);
        cfg_write(2'd3, 32'h4);
        check(!cfg_err, "R8 R9 clear err", cfg_err, 0);
        // Sweep: all modes, short lengths, skip around the record end
        for (int m = 0; m < 5; m++)
            for (int l = 0; l < 5; l++)
                if (m == 4) for (int s = 0; s < 7; s++) run_record(m, l, s);
                else run_record(m, l, 0);
        // R8: changes during an active record are refused
        cfg_write(2'd0, 32'd1);
        cfg_write(2'd1, 32'd3);
        cfg_write(2'd3, 32'h1);
        check(busy, "R8 busy after start", busy, 1);
        cfg_write(2'd0, 32'd2);
        check(cfg_err && !port_a_is_out, "R8 mode write while active", {cfg_err, port_a_is_out}, 2);
        cfg_write(2'd3, 32'h4);
        cfg_write(2'd1, 32'd9);
        check(cfg_err, "R8 length write while active", cfg_err, 1);
        got = 0;
        a_in_valid = 1; a_in_data = 8'h3C; b_out_ready = 1;
        for (int c = 0; c < 30; c++) begin
            #2;
            if (b_out_valid && b_out_ready) got++;
            @(negedge clk);
        end
        a_in_valid = 0;
        check(got == 3 && done, "R4 R8 length kept", got, 3);
        // R7: a new record while done is still set keeps done set
        cfg_write(2'd3, 32'h1);
        check(done, "R7 sticky across start", done, 1);
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule